// File: doc/BRIEF.md
# FIFO-Fed DMA Drain Channel

This block is one DMA channel that empties a four-word, 16-bit staging FIFO into a destination memory. A host pushes words into the FIFO through a fill port. Software programs a destination address, a transfer count and a channel control word through dedicated write strobes. A host-side remaining-length counter is also loaded this way.

Once the FIFO holds four words, the channel is enabled and the count is nonzero, the block raises a peripheral request. On the next clock it starts a burst that writes up to four words, one per cycle, through a simple synchronous memory write port. Each write goes to the current destination address, which then advances by two bytes. Each write also decrements the transfer count.

Two conditions end the transfer, and they are tracked apart. When the channel count reaches zero, the end flag in the control word is set. When a word is drained while the host's remaining length is already zero, the transfer-active status drops.

Top module: `dma_drain_chan`

## Requirements
- R1: After reset the FIFO is empty, and the full flag, active flag, control word, request and memory write strobe are all 0.
- R2: `dreq_o` is high only while the FIFO holds exactly 4 words, control bit 0 (enable) is 1, the count is nonzero and no burst is running. The burst begins on the clock edge where `dreq_o` is high.
- R3: During a burst, the block removes one word per cycle, in push order. A burst ends after 4 words or when the count reaches zero. One edge after each removal, `mem_we_o` is high for one cycle, `mem_addr_o` holds the destination address from before the removal, and `mem_wdata_o` holds the word.
- R4: The destination address increases by 2 for each drained word.
- R5: The transfer count decreases by 1 for each drained word, and no word is drained while the count is zero.
- R6: A count write keeps only the low 24 bits of `tcr_data_i`.
- R7: Control bit 1 (end flag) is set on the edge where a drained word brings the count to zero.
- R8: A host word offered while the FIFO is full and no word leaves is dropped. The full flag is set when the FIFO becomes full or a word is dropped, and it is cleared by any drained word.
- R9: A length write loads the remaining length and sets the active flag when the value is nonzero. Each accepted host word decrements a nonzero length. A word drained while the length is zero clears the active flag.
- R10: A register write strobe takes precedence over the drain update of that same register on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Host offers a word to the FIFO |
| fill_data_i | input | 16 | Host word |
| len_wr_i | input | 1 | Load host remaining length |
| len_data_i | input | 16 | Remaining length value |
| dar_wr_i | input | 1 | Load destination address |
| dar_data_i | input | 32 | Destination address value |
| tcr_wr_i | input | 1 | Load transfer count |
| tcr_data_i | input | 32 | Transfer count value (low 24 bits kept) |
| ctrl_wr_i | input | 1 | Load channel control word |
| ctrl_data_i | input | 16 | Control word (bit 0 enable, bit 1 end) |
| dar_o | output | 32 | Current destination address |
| tcr_o | output | 24 | Current transfer count |
| ctrl_o | output | 16 | Current control word |
| fifo_full_o | output | 1 | FIFO-full status flag |
| xfer_active_o | output | 1 | Host transfer-active status |
| dreq_o | output | 1 | Peripheral request |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory write address |
| mem_wdata_o | output | 16 | Memory write data |

## Verification
The request is combinational from state, so it is due in the same cycle that the fourth word lands. The first memory write appears two edges after that word is pushed: one edge to start the burst and one to register the write. The address, count, end flag, full flag and active flag all move on the same edge as the write strobe they belong to. A behavioural model built on a queue advances on each rising edge from the same inputs. All outputs are compared against it at every falling edge, so each result is checked in exactly the cycle it is due. Named checks add the masked count load, the dropped words, the early end on count exhaustion and the active-flag drop.

// File: rtl/dma_drain_pkg.sv
package dma_drain_pkg;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_END_BIT = 1;
endpackage

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> cnt_q != CNT_W'(DEPTH)); // R8
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_drain_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TCNT_W = 24,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned STEP   = 2,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dar_wr_i,
  input  logic [ADDR_W-1:0] dar_data_i,
  input  logic              tcr_wr_i,
  input  logic [31:0]       tcr_data_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  input  logic              len_wr_i,
  input  logic [LEN_W-1:0]  len_data_i,
  input  logic              pop_i,
  input  logic              push_acc_i,
  input  logic              drop_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] dar_o,
  output logic [TCNT_W-1:0] tcnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              full_o,
  output logic              active_o
);
  logic [ADDR_W-1:0] dar_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LEN_W-1:0]  len_q;
  logic              full_q, active_q;
  logic              becomes_full;

  assign becomes_full = (push_acc_i && count_i == CNT_W'(DEPTH - 1)) || drop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dar_q    <= '0;
      tcnt_q   <= '0;
      ctrl_q   <= '0;
      len_q    <= '0;
      full_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (dar_wr_i)   dar_q <= dar_data_i;
      else if (pop_i) dar_q <= dar_q + ADDR_W'(STEP);

      if (tcr_wr_i)   tcnt_q <= tcr_data_i[TCNT_W-1:0];
      else if (pop_i) tcnt_q <= tcnt_q - TCNT_W'(1);

      if (ctrl_wr_i) ctrl_q <= ctrl_data_i;
      else if (pop_i && tcnt_q == TCNT_W'(1)) ctrl_q[CTRL_END_BIT] <= 1'b1;

      if (pop_i)             full_q <= 1'b0;
      else if (becomes_full) full_q <= 1'b1;

      if (len_wr_i) begin
        len_q    <= len_data_i;
        active_q <= |len_data_i;
      end else begin
        if (pop_i && len_q == '0)       active_q <= 1'b0;
        if (push_acc_i && len_q != '0)  len_q    <= len_q - LEN_W'(1);
      end
    end
  end

  assign dar_o    = dar_q;
  assign tcnt_o   = tcnt_q;
  assign ctrl_o   = ctrl_q;
  assign full_o   = full_q;
  assign active_o = active_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !dar_wr_i) |=> dar_q == $past(dar_q) + ADDR_W'(STEP)); // R4
  AST_TCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !tcr_wr_i) |=> tcnt_q == $past(tcnt_q) - TCNT_W'(1)); // R5
  AST_NO_DRAIN_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> tcnt_q != '0); // R5
  AST_END_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !ctrl_wr_i && tcnt_q == TCNT_W'(1)) |=> ctrl_q[CTRL_END_BIT]); // R7
  AST_FULL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> !full_q); // R8
  AST_ACTIVE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !len_wr_i && len_q == '0) |=> !active_q); // R9
endmodule

// File: rtl/dma_drain_ctrl.sv
module dma_drain_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned BC_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              enable_i,
  input  logic              tcnt_zero_i,
  input  logic              tcnt_one_i,
  input  logic [ADDR_W-1:0] dar_i,
  input  logic [DATA_W-1:0] head_i,
  output logic              dreq_o,
  output logic              pop_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              drain_q;
  logic [BC_W-1:0]   bc_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              group_done;

  assign dreq_o     = !drain_q && count_i == CNT_W'(DEPTH) && enable_i && !tcnt_zero_i;
  assign pop_o      = drain_q && count_i != '0 && !tcnt_zero_i;
  assign group_done = (bc_q == BC_W'(DEPTH - 1)) || tcnt_one_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      bc_q    <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (dreq_o) begin
        drain_q <= 1'b1;
        bc_q    <= '0;
      end else if (pop_o) begin
        bc_q <= bc_q + BC_W'(1);
        if (group_done) drain_q <= 1'b0;
      end else begin
        drain_q <= 1'b0;
      end
      we_q <= pop_o;
      if (pop_o) begin
        addr_q  <= dar_i;
        wdata_q <= head_i;
      end
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  AST_WE_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> mem_we_o); // R3
  AST_WE_NEEDS_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(pop_o)); // R3
  AST_BURST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drain_q) |-> $past(count_i) == CNT_W'(DEPTH)); // R2
  AST_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |=> !dreq_o); // R2
endmodule

// File: rtl/dma_drain_chan.sv
module dma_drain_chan
  import dma_drain_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TCNT_W = 24,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned STEP  = DATA_W / 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              len_wr_i,
  input  logic [LEN_W-1:0]  len_data_i,
  input  logic              dar_wr_i,
  input  logic [ADDR_W-1:0] dar_data_i,
  input  logic              tcr_wr_i,
  input  logic [31:0]       tcr_data_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  output logic [ADDR_W-1:0] dar_o,
  output logic [TCNT_W-1:0] tcr_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              fifo_full_o,
  output logic              xfer_active_o,
  output logic              dreq_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] head;
  logic              pop, push_acc, drop;

  assign push_acc = fill_valid_i && (count != CNT_W'(DEPTH) || pop);
  assign drop     = fill_valid_i && !push_acc;

  dma_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_acc),
    .pop_i   (pop),
    .wdata_i (fill_data_i),
    .rdata_o (head),
    .count_o (count)
  );

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .TCNT_W(TCNT_W), .CTRL_W(CTRL_W),
    .LEN_W(LEN_W), .STEP(STEP), .DEPTH(DEPTH)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dar_wr_i    (dar_wr_i),
    .dar_data_i  (dar_data_i),
    .tcr_wr_i    (tcr_wr_i),
    .tcr_data_i  (tcr_data_i),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_data_i (ctrl_data_i),
    .len_wr_i    (len_wr_i),
    .len_data_i  (len_data_i),
    .pop_i       (pop),
    .push_acc_i  (push_acc),
    .drop_i      (drop),
    .count_i     (count),
    .dar_o       (dar_o),
    .tcnt_o      (tcr_o),
    .ctrl_o      (ctrl_o),
    .full_o      (fifo_full_o),
    .active_o    (xfer_active_o)
  );

  dma_drain_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_i     (count),
    .enable_i    (ctrl_o[CTRL_EN_BIT]),
    .tcnt_zero_i (tcr_o == '0),
    .tcnt_one_i  (tcr_o == TCNT_W'(1)),
    .dar_i       (dar_o),
    .head_i      (head),
    .dreq_o      (dreq_o),
    .pop_o       (pop),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  AST_DROP_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> fifo_full_o); // R8
  AST_DAR_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dar_wr_i |=> dar_o == $past(dar_data_i)); // R10
endmodule

// File: tb/sim_dma_drain_chan.sv
module sim_dma_drain_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fill_valid;
  logic [15:0] fill_data;
  logic        len_wr, dar_wr, tcr_wr, ctrl_wr;
  logic [15:0] len_data, ctrl_data;
  logic [31:0] dar_data, tcr_data;
  logic [31:0] dar, mem_addr;
  logic [23:0] tcr;
  logic [15:0] ctrl, mem_wdata;
  logic        fifo_full, xfer_active, dreq, mem_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_drain_chan u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .len_wr_i(len_wr), .len_data_i(len_data),
    .dar_wr_i(dar_wr), .dar_data_i(dar_data),
    .tcr_wr_i(tcr_wr), .tcr_data_i(tcr_data),
    .ctrl_wr_i(ctrl_wr), .ctrl_data_i(ctrl_data),
    .dar_o(dar), .tcr_o(tcr), .ctrl_o(ctrl),
    .fifo_full_o(fifo_full), .xfer_active_o(xfer_active), .dreq_o(dreq),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  // behavioural reference model
  int          q[$];
  logic [31:0] m_dar, m_addr;
  logic [23:0] m_tcr, old_tcr;
  logic [15:0] m_ctrl, m_len, m_wd, old_len;
  bit          m_full, m_act, m_drn, m_we;
  int          m_bc, sz;
  bit          dq, pp, acc, drp;

  function automatic bit m_dreq();
    return !m_drn && q.size() == 4 && m_ctrl[0] && m_tcr != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_dar = 0; m_tcr = 0; m_ctrl = 0; m_len = 0; m_wd = 0; m_addr = 0;
      m_full = 0; m_act = 0; m_drn = 0; m_we = 0; m_bc = 0;
    end else begin
      sz = q.size();
      dq = m_dreq();
      pp = m_drn && sz != 0 && m_tcr != 0;
      acc = fill_valid && (sz < 4 || pp);
      drp = fill_valid && !acc;
      old_tcr = m_tcr; old_len = m_len;
      m_we = pp;
      if (pp) begin
        m_addr = m_dar;
        m_wd = 16'(q.pop_front());
        m_dar = m_dar + 2;
        m_tcr = m_tcr - 1;
        if (m_tcr == 0) m_ctrl[1] = 1'b1;
      end
      if (acc) q.push_back(int'(fill_data));
      if (pp) m_full = 0;
      else if ((acc && sz == 3) || drp) m_full = 1;
      if (len_wr) begin
        m_len = len_data; m_act = (len_data != 0);
      end else begin
        if (pp && old_len == 0) m_act = 0;
        if (acc && m_len != 0) m_len = m_len - 1;
      end
      if (dq) begin m_drn = 1; m_bc = 0; end
      else if (pp) begin
        m_bc++;
        if (m_bc == 4 || old_tcr == 1) m_drn = 0;
      end else m_drn = 0;
      if (dar_wr)  m_dar  = dar_data;
      if (tcr_wr)  m_tcr  = tcr_data[23:0];
      if (ctrl_wr) m_ctrl = ctrl_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(dreq == m_dreq(), "R2 dreq", dreq, m_dreq());
    chk(mem_we == m_we, "R3 mem_we", mem_we, m_we);
    if (m_we) begin
      chk(mem_addr == m_addr, "R3 mem_addr", mem_addr, m_addr);
      chk(mem_wdata == m_wd, "R3 mem_wdata", mem_wdata, m_wd);
    end
    chk(dar == m_dar, "R4 dar", dar, m_dar);
    chk(tcr == m_tcr, "R5 tcr", tcr, m_tcr);
    chk(ctrl == m_ctrl, "R7 ctrl", ctrl, m_ctrl);
    chk(fifo_full == m_full, "R8 full", fifo_full, m_full);
    chk(xfer_active == m_act, "R9 active", xfer_active, m_act);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    fill_valid = 0; len_wr = 0; dar_wr = 0; tcr_wr = 0; ctrl_wr = 0;
  endtask

  task automatic push_word(input logic [15:0] w);
    fill_valid = 1; fill_data = w;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fill_valid = 0; fill_data = 0;
    len_wr = 0; dar_wr = 0; tcr_wr = 0; ctrl_wr = 0;
    len_data = 0; dar_data = 0; tcr_data = 0; ctrl_data = 0;
    idle(2);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(!fifo_full && !xfer_active && !dreq && !mem_we && ctrl == 0, "R1 reset",
        {fifo_full, xfer_active, dreq, mem_we}, 0);

    // scenario: count 10, length 10, three groups
    dar_wr = 1; dar_data = 32'h1000;
    tcr_wr = 1; tcr_data = 10;
    ctrl_wr = 1; ctrl_data = 16'h0001;
    len_wr = 1; len_data = 10;
    tick();
    chk(xfer_active == 1, "R9 active set", xfer_active, 1);
    for (int i = 0; i < 4; i++) push_word(16'hA000 + 16'(i));
    chk(dreq == 1, "R2 dreq at four words", dreq, 1);
    idle(8);
    chk(dar == 32'h1008 && tcr == 6, "R4 R5 after group", {dar, 8'h0, tcr}, {32'h1008, 8'h0, 24'd6});
    for (int i = 0; i < 4; i++) push_word(16'hB000 + 16'(i));
    idle(8);
    push_word(16'hC000); push_word(16'hC001);
    idle(3);
    chk(dreq == 0, "R2 no dreq below four", dreq, 0);
    push_word(16'hC002); push_word(16'hC003);
    idle(8);
    chk(tcr == 0, "R5 count exhausted", tcr, 0);
    chk(ctrl[1] == 1, "R7 end flag", ctrl[1], 1);
    chk(xfer_active == 0, "R9 active cleared", xfer_active, 0);
    chk(dar == 32'h1014, "R3 stop after two", dar, 32'h1014);

    // async reset in the middle
    rst_n = 0;
    tick();
    rst_n = 1;
    tick();
    chk(!fifo_full && ctrl == 0 && tcr == 0, "R1 second reset", {fifo_full, ctrl}, 0);

    // masked count, dropped words, disabled request
    tcr_wr = 1; tcr_data = 32'hFFFF_FF05;
    dar_wr = 1; dar_data = 32'h2000;
    ctrl_wr = 1; ctrl_data = 16'h0000;
    len_wr = 1; len_data = 3;
    tick();
    chk(tcr == 24'hFFFF05, "R6 count mask", tcr, 24'hFFFF05);
    for (int i = 0; i < 6; i++) push_word(16'hD000 + 16'(i));
    chk(fifo_full == 1, "R8 full after drop", fifo_full, 1);
    chk(dreq == 0, "R2 no dreq disabled", dreq, 0);
    ctrl_wr = 1; ctrl_data = 16'h0001;
    tick();
    idle(8);
    chk(fifo_full == 0, "R8 full cleared", fifo_full, 0);
    chk(dar == 32'h2008, "R8 only four drained", dar, 32'h2008);

    // back-to-back pushes overlapping drains
    for (int i = 0; i < 9; i++) push_word(16'hE000 + 16'(i));
    idle(12);

    // register write beats drain update
    for (int i = 0; i < 4; i++) push_word(16'hF000 + 16'(i));
    tick();
    dar_wr = 1; dar_data = 32'h4000;
    tick();
    chk(dar == 32'h4000, "R10 write wins", dar, 32'h4000);
    idle(8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule